// File: doc/BRIEF.md
# Address-Space Slot Allocator with Recency Reclaim

This block shares a small pool of hardware address-space slots among a larger population of contexts. Each cycle it accepts at most one request naming a context and an operation. A get returns the slot that context already holds. If the context holds none, the get hands out a free slot, or takes a slot back from an idle holder. A put drops one reference. A free gives the context's slot back to the pool, and a clear wipes all allocation state.

Per context, the allocator tracks whether a slot is held, which slot it is and a saturating reference count. Per slot, it tracks the owner, an allocated bit and a recency rank. When reclaim is needed, the slot chosen is the least recently used one whose owner has no references left. A hit refreshes recency. Each fresh assignment emits a one-cycle program pulse carrying the slot number, so that neighbouring logic can load that slot's translation setup. Every response is registered and appears in the cycle after the request.

Top module: `asa_allocator`

## Requirements
- R1: A get (req_op 0) for a context that already holds a slot returns that slot with rsp_hit high. It adds one to the context's count, makes the slot the most recently used and leaves alloc_mask unchanged.
- R2: ref_warn pulses with a hit response when the incremented count is at least JOB_SLOTS+1. The count saturates at its maximum value instead of wrapping.
- R3: A get from a context without a slot first looks at the lowest-numbered clear bit of alloc_mask. That slot is taken only if its bit in present_mask is set. Otherwise the allocator falls through to reclaim, even if a higher free slot is present.
- R4: Reclaim picks, among allocated slots whose owner has count zero, the least recently used one. Its former owner then holds no slot, so that owner's next get is a fresh assignment.
- R5: A fresh assignment gives the requesting context count 1, sets the slot's bit in alloc_mask and makes the slot the most recently used.
- R6: A fresh assignment raises prog_pulse for one cycle, with prog_slot equal to rsp_slot. A hit, a failure and the put, free and clear operations raise no pulse.
- R7: Reset (rst_n low) and the clear operation (req_op 3) empty alloc_mask, leave every context without a slot and with count 0, and restore the recency order.
- R8: A free (req_op 2) of a context that holds a slot clears that slot's alloc_mask bit and removes it from recency consideration. A free of a context without a slot changes nothing.
- R9: When a get needs a fresh slot and neither a present free slot nor a reclaimable slot exists, rsp_fail pulses. rsp_slot is 0 and no state changes.
- R10: A put (req_op 1) lowers the context's count by one. At count 0 the count stays 0 and ref_underflow pulses.
- R11: rsp_valid is high exactly in the cycle after each cycle with req_valid high. For put, free and clear requests, rsp_slot is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 get, 1 put, 2 free, 3 clear |
| req_ctx | input | CTX_W | Context identifier |
| present_mask | input | NUM_SLOTS | Slots that exist in hardware |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Get found an existing slot |
| rsp_fail | output | 1 | Get could not obtain a slot |
| rsp_slot | output | SLOT_W | Slot returned by a get |
| prog_pulse | output | 1 | New assignment; program the slot |
| prog_slot | output | SLOT_W | Slot to program |
| ref_warn | output | 1 | Count reached the warning level |
| ref_underflow | output | 1 | Put at count zero |
| alloc_mask | output | NUM_SLOTS | Allocated slots |

## Verification
A single get can both evict an idle holder and hand its slot to the requester, so the eviction and the new assignment land in the same registered update. The bench fills every slot and drops the counts of two holders. It then issues gets from contexts that hold nothing. Each such get must return the older idle holder's slot with a program pulse. A later get from the evicted context must be a fresh assignment rather than a hit. A further sequence makes one holder a hit and then idle again, which moves it ahead in recency, so the next reclaim must skip it.

// File: rtl/asa_pkg.sv
package asa_pkg;

    typedef enum logic [1:0] {
        OP_GET   = 2'd0,
        OP_PUT   = 2'd1,
        OP_FREE  = 2'd2,
        OP_CLEAR = 2'd3
    } asa_op_e;

endpackage

// File: rtl/asa_free_pick.sv
// Finds the lowest clear allocation bit; usable only when that slot is present.
module asa_free_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] amask,
    input  logic [N-1:0] present,
    output logic         found,
    output logic [W-1:0] idx
);
    logic any_clear;

    always_comb begin
        any_clear = 1'b0;
        idx       = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!amask[i]) begin
                any_clear = 1'b1;
                idx       = W'(i);
            end
        end
        found = any_clear && present[idx];
    end
endmodule

// File: rtl/asa_victim_pick.sv
// Among eligible slots, picks the one with the largest rank (oldest use).
module asa_victim_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0]        elig,
    input  logic [N-1:0][W-1:0] rank,
    output logic                found,
    output logic [W-1:0]        idx
);
    logic [W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!found || rank[i] > best)) begin
                found = 1'b1;
                idx   = W'(i);
                best  = rank[i];
            end
        end
    end
endmodule

// File: rtl/asa_rank_next.sv
// Recency ranks form a permutation: 0 is most recent, N-1 is oldest.
module asa_rank_next #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0][W-1:0] rank,
    input  logic                touch_en,
    input  logic [W-1:0]        touch_idx,
    input  logic                retire_en,
    input  logic [W-1:0]        retire_idx,
    output logic [N-1:0][W-1:0] rank_nxt
);
    localparam logic [W-1:0] OLDEST = W'(N - 1);

    logic [W-1:0] touch_rank;
    logic [W-1:0] retire_rank;

    assign touch_rank  = rank[touch_idx];
    assign retire_rank = rank[retire_idx];

    for (genvar s = 0; s < N; s++) begin : g_slot
        localparam logic [W-1:0] SELF = W'(s);
        logic [W-1:0] on_touch;
        logic [W-1:0] on_retire;

        assign on_touch  = (SELF == touch_idx) ? '0 :
                           (rank[s] < touch_rank) ? rank[s] + 1'b1 : rank[s];
        assign on_retire = (SELF == retire_idx) ? OLDEST :
                           (rank[s] > retire_rank) ? rank[s] - 1'b1 : rank[s];
        assign rank_nxt[s] = touch_en  ? on_touch  :
                             retire_en ? on_retire : rank[s];
    end
endmodule

// File: rtl/asa_allocator.sv
module asa_allocator
    import asa_pkg::*;
#(
    parameter int NUM_CTX   = 8,
    parameter int NUM_SLOTS = 4,
    parameter int JOB_SLOTS = 2,
    localparam int CTX_W    = $clog2(NUM_CTX),
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int REF_W    = $clog2(JOB_SLOTS + 2) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_op,
    input  logic [CTX_W-1:0]     req_ctx,
    input  logic [NUM_SLOTS-1:0] present_mask,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_fail,
    output logic [SLOT_W-1:0]    rsp_slot,
    output logic                 prog_pulse,
    output logic [SLOT_W-1:0]    prog_slot,
    output logic                 ref_warn,
    output logic                 ref_underflow,
    output logic [NUM_SLOTS-1:0] alloc_mask
);
    localparam logic [REF_W-1:0] WARN_AT = REF_W'(JOB_SLOTS + 1);
    localparam logic [REF_W-1:0] REF_MAX = '1;

    typedef struct packed {
        logic [NUM_CTX-1:0]                has;
        logic [NUM_CTX-1:0][SLOT_W-1:0]    slot;
        logic [NUM_CTX-1:0][REF_W-1:0]     refc;
        logic [NUM_SLOTS-1:0]              amask;
        logic [NUM_SLOTS-1:0][CTX_W-1:0]   owner;
        logic [NUM_SLOTS-1:0][SLOT_W-1:0]  rank;
        logic                              rsp_valid;
        logic                              rsp_hit;
        logic                              rsp_fail;
        logic [SLOT_W-1:0]                 rsp_slot;
        logic                              prog;
        logic [SLOT_W-1:0]                 prog_slot;
        logic                              warn;
        logic                              under;
    } state_t;

    function automatic state_t reset_value();
        state_t s;
        s = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            s.rank[i] = SLOT_W'(i);
        end
        return s;
    endfunction

    state_t q, d;

    asa_op_e            op;
    logic [SLOT_W-1:0]  cur_slot;
    logic [REF_W-1:0]   cur_ref;
    logic [REF_W-1:0]   ref_inc;
    logic               cur_has;
    logic               is_get;
    logic               do_hit;
    logic               do_new;
    logic               do_evict;
    logic [SLOT_W-1:0]  new_slot;
    logic               touch_en;
    logic [SLOT_W-1:0]  touch_idx;
    logic               retire_en;

    logic [NUM_SLOTS-1:0]             elig;
    logic                             free_found;
    logic [SLOT_W-1:0]                free_idx;
    logic                             vic_found;
    logic [SLOT_W-1:0]                vic_idx;
    logic [NUM_SLOTS-1:0][SLOT_W-1:0] rank_nxt;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_elig
        assign elig[s] = q.amask[s] && (q.refc[q.owner[s]] == '0);
    end

    asa_free_pick #(.N(NUM_SLOTS), .W(SLOT_W)) u_free (
        .amask   (q.amask),
        .present (present_mask),
        .found   (free_found),
        .idx     (free_idx)
    );

    asa_victim_pick #(.N(NUM_SLOTS), .W(SLOT_W)) u_victim (
        .elig  (elig),
        .rank  (q.rank),
        .found (vic_found),
        .idx   (vic_idx)
    );

    asa_rank_next #(.N(NUM_SLOTS), .W(SLOT_W)) u_rank (
        .rank       (q.rank),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .retire_en  (retire_en),
        .retire_idx (cur_slot),
        .rank_nxt   (rank_nxt)
    );

    // Request decode: which path a request takes, and what it does to recency.
    always_comb begin
        op       = asa_op_e'(req_op);
        cur_has  = q.has[req_ctx];
        cur_slot = q.slot[req_ctx];
        cur_ref  = q.refc[req_ctx];
        ref_inc  = (cur_ref == REF_MAX) ? cur_ref : cur_ref + 1'b1;

        is_get   = req_valid && (op == OP_GET);
        do_hit   = is_get && cur_has;
        do_new   = is_get && !cur_has && (free_found || vic_found);
        do_evict = do_new && !free_found;
        new_slot = free_found ? free_idx : vic_idx;

        touch_en  = do_hit || do_new;
        touch_idx = do_hit ? cur_slot : new_slot;
        retire_en = req_valid && (op == OP_FREE) && cur_has;
    end

    // Next-state computation.
    always_comb begin
        d           = q;
        d.rank      = rank_nxt;
        d.rsp_valid = req_valid;
        d.rsp_hit   = 1'b0;
        d.rsp_fail  = 1'b0;
        d.rsp_slot  = '0;
        d.prog      = 1'b0;
        d.prog_slot = '0;
        d.warn      = 1'b0;
        d.under     = 1'b0;

        if (req_valid) begin
            unique case (op)
                OP_GET: begin
                    if (do_hit) begin
                        d.rsp_hit       = 1'b1;
                        d.rsp_slot      = cur_slot;
                        d.refc[req_ctx] = ref_inc;
                        d.warn          = (ref_inc >= WARN_AT);
                    end else if (do_new) begin
                        if (do_evict) begin
                            d.has[q.owner[new_slot]] = 1'b0;
                        end
                        d.has[req_ctx]   = 1'b1;
                        d.slot[req_ctx]  = new_slot;
                        d.refc[req_ctx]  = REF_W'(1);
                        d.amask[new_slot] = 1'b1;
                        d.owner[new_slot] = req_ctx;
                        d.rsp_slot       = new_slot;
                        d.prog           = 1'b1;
                        d.prog_slot      = new_slot;
                    end else begin
                        d.rsp_fail = 1'b1;
                    end
                end
                OP_PUT: begin
                    if (cur_ref == '0) begin
                        d.under = 1'b1;
                    end else begin
                        d.refc[req_ctx] = cur_ref - 1'b1;
                    end
                end
                OP_FREE: begin
                    if (cur_has) begin
                        d.has[req_ctx]    = 1'b0;
                        d.refc[req_ctx]   = '0;
                        d.amask[cur_slot] = 1'b0;
                    end
                end
                OP_CLEAR: begin
                    d           = reset_value();
                    d.rsp_valid = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= reset_value();
        end else begin
            q <= d;
        end
    end

    assign rsp_valid     = q.rsp_valid;
    assign rsp_hit       = q.rsp_hit;
    assign rsp_fail      = q.rsp_fail;
    assign rsp_slot      = q.rsp_slot;
    assign prog_pulse    = q.prog;
    assign prog_slot     = q.prog_slot;
    assign ref_warn      = q.warn;
    assign ref_underflow = q.under;
    assign alloc_mask    = q.amask;

endmodule

// File: rtl/asa_checker.sv
module asa_checker #(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic                 rsp_fail,
    input logic [SLOT_W-1:0]    rsp_slot,
    input logic                 prog_pulse,
    input logic [SLOT_W-1:0]    prog_slot,
    input logic                 ref_warn,
    input logic                 ref_underflow,
    input logic [NUM_SLOTS-1:0] alloc_mask
);
    AST_HIT_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid && !prog_pulse && $stable(alloc_mask)); // R1

    AST_WARN_WITH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ref_warn |-> rsp_hit); // R2

    AST_NEW_SLOT_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse |-> alloc_mask[prog_slot]); // R5

    AST_PROG_MATCHES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse |-> rsp_valid && !rsp_fail && (prog_slot == rsp_slot)); // R6

    AST_FAIL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fail |-> !prog_pulse && (rsp_slot == '0) && $stable(alloc_mask)); // R9

    AST_UNDER_IS_PUT: assert property (@(posedge clk) disable iff (!rst_n)
        ref_underflow |-> rsp_valid && !rsp_hit && !rsp_fail && !prog_pulse); // R10

    AST_RSP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit && !rsp_fail && !prog_pulse); // R11
endmodule

bind asa_allocator asa_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W)
) u_asa_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_fail      (rsp_fail),
    .rsp_slot      (rsp_slot),
    .prog_pulse    (prog_pulse),
    .prog_slot     (prog_slot),
    .ref_warn      (ref_warn),
    .ref_underflow (ref_underflow),
    .alloc_mask    (alloc_mask)
);

// File: tb/tb_asa_allocator.sv
module tb_asa_allocator;
    localparam int CLK_PERIOD = 10;
    localparam int NCTX   = 8;
    localparam int NSLOT  = 4;

    typedef struct packed {
        logic [1:0] op;
        logic [2:0] ctx;
        logic       hit;
        logic       fail;
        logic       prog;
        logic [1:0] slot;
        logic       warn;
        logic       under;
        logic [3:0] mask;
    } vec_t;

    // op: 0 get, 1 put, 2 free, 3 clear
    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 4'b0001}, // R5 first assignment
        '{2'd0, 3'd1, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 4'b0011},
        '{2'd0, 3'd2, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 4'b0111},
        '{2'd0, 3'd3, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 4'b1111},
        '{2'd0, 3'd4, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 4'b1111}, // R9 all busy
        '{2'd1, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'b1111},
        '{2'd1, 3'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'b1111},
        '{2'd0, 3'd4, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 4'b1111}, // R4 evict ctx1
        '{2'd0, 3'd1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 4'b1111}, // R4 ctx1 new, evict ctx2
        '{2'd0, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'b1111}, // R1 hit
        '{2'd0, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 4'b1111}, // R2 count 3
        '{2'd1, 3'd5, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 4'b1111}, // R10 no slot
        '{2'd2, 3'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'b0111}, // R8 free
        '{2'd0, 3'd6, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 4'b1111}, // R3 lowest clear
        '{2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'b1111},
        '{2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'b1111},
        '{2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'b1111},
        '{2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 4'b1111}  // R10 saturate
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_op = 2'd0;
    logic [2:0]       req_ctx = 3'd0;
    logic [NSLOT-1:0] present_mask = 4'b1111;
    logic             rsp_valid, rsp_hit, rsp_fail, prog_pulse, ref_warn, ref_underflow;
    logic [1:0]       rsp_slot, prog_slot;
    logic [NSLOT-1:0] alloc_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    asa_allocator #(.NUM_CTX(NCTX), .NUM_SLOTS(NSLOT), .JOB_SLOTS(2)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_ctx       (req_ctx),
        .present_mask  (present_mask),
        .rsp_valid     (rsp_valid),
        .rsp_hit       (rsp_hit),
        .rsp_fail      (rsp_fail),
        .rsp_slot      (rsp_slot),
        .prog_pulse    (prog_pulse),
        .prog_slot     (prog_slot),
        .ref_warn      (ref_warn),
        .ref_underflow (ref_underflow),
        .alloc_mask    (alloc_mask)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one request; return at the falling edge after the capturing edge.
    task automatic req(input logic [1:0] op, input logic [2:0] ctx);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_ctx   = ctx;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7 reset state
        chk("R7 reset alloc_mask", int'(alloc_mask), 0);
        chk("R11 reset rsp_valid", int'(rsp_valid), 0);
        chk("R6 reset prog_pulse", int'(prog_pulse), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            req(VECS[i].op, VECS[i].ctx);
            chk($sformatf("R11 v%0d rsp_valid", i), int'(rsp_valid), 1);
            chk($sformatf("R1 v%0d rsp_hit", i), int'(rsp_hit), int'(VECS[i].hit));
            chk($sformatf("R9 v%0d rsp_fail", i), int'(rsp_fail), int'(VECS[i].fail));
            chk($sformatf("R6 v%0d prog_pulse", i), int'(prog_pulse), int'(VECS[i].prog));
            chk($sformatf("R3 v%0d rsp_slot", i), int'(rsp_slot), int'(VECS[i].slot));
            if (VECS[i].prog)
                chk($sformatf("R6 v%0d prog_slot", i), int'(prog_slot), int'(VECS[i].slot));
            chk($sformatf("R2 v%0d ref_warn", i), int'(ref_warn), int'(VECS[i].warn));
            chk($sformatf("R10 v%0d ref_underflow", i), int'(ref_underflow), int'(VECS[i].under));
            chk($sformatf("R5 v%0d alloc_mask", i), int'(alloc_mask), int'(VECS[i].mask));
        end

        // R11 idle cycle gives no response
        @(negedge clk);
        chk("R11 idle rsp_valid", int'(rsp_valid), 0);

        // R7 clear operation
        req(2'd3, 3'd0);
        chk("R7 clear alloc_mask", int'(alloc_mask), 0);
        chk("R11 clear rsp_valid", int'(rsp_valid), 1);
        req(2'd0, 3'd0);
        chk("R7 after clear not hit", int'(rsp_hit), 0);
        chk("R7 after clear prog", int'(prog_pulse), 1);
        chk("R7 after clear slot", int'(rsp_slot), 0);

        // R4 hit refreshes recency, reclaim skips the refreshed holder
        for (int c = 1; c < 4; c++) req(2'd0, 3'(c));
        for (int c = 0; c < 4; c++) req(2'd1, 3'(c));
        req(2'd0, 3'd0);
        chk("R1 refreshed hit", int'(rsp_hit), 1);
        req(2'd1, 3'd0);
        req(2'd0, 3'd5);
        chk("R4 reclaim oldest idle slot", int'(rsp_slot), 1);
        chk("R4 reclaim prog", int'(prog_pulse), 1);
        req(2'd0, 3'd1);
        chk("R4 evicted ctx not hit", int'(rsp_hit), 0);
        chk("R4 evicted ctx slot", int'(rsp_slot), 2);

        // R8 free of a non-holder has no effect; free of a holder clears its bit
        req(2'd2, 3'd7);
        chk("R8 free non-holder mask", int'(alloc_mask), 15);
        req(2'd2, 3'd5);
        chk("R8 free holder mask", int'(alloc_mask), 13);
        req(2'd0, 3'd7);
        chk("R8 reuse freed slot", int'(rsp_slot), 1);

        // R3 lowest clear slot absent: no fallback to a higher free slot
        req(2'd3, 3'd0);
        present_mask = 4'b1110;
        req(2'd0, 3'd0);
        chk("R3 absent lowest slot fail", int'(rsp_fail), 1);
        chk("R3 absent lowest slot mask", int'(alloc_mask), 0);
        present_mask = 4'b1111;
        req(2'd0, 3'd0);
        chk("R3 present lowest slot", int'(prog_pulse), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule